// File: doc/BRIEF.md
# Two-Level Graphics Aperture Address Translator

This block turns a bus address that falls inside a graphics aperture into a physical memory address. Translation walks two levels. The first level is a 64-entry directory held in flops. Each directory entry names the page that holds one second-level table in system memory. The second-level entry is fetched over a plain read port with request and acknowledge. A four-entry translation cache keeps recent results, so a repeated page completes one cycle after the request.

Software sets up the block through a 32-bit configuration write port. The port holds four registers: the aperture base, an aperture size code, a control word and a packed directory-load word. A drop and then a rise of control bit 7 empties the translation cache.

Each translation ends with a one-cycle done strobe. The strobe comes with a fault flag, a cache-hit flag and the translated address. The address reads zero on a fault.

Top module: `gart_xlate`

## Requirements
- R1: After reset the done strobe and the memory read request are low, and the translation cache is empty, so the first translation of any page reads memory.
- R2: The page index is {address[31:22] minus base[31:22], address[21:12]}. When this index is not below the aperture page count, the translation ends with fault=1, paddr=0 and no memory read. Addresses below the base also fault this way, because the subtraction wraps.
- R3: Size codes written at offset 0xB4 (bits 7:0) set the page count: 0 gives 65536, 32 gives 32768, 48 gives 16384 and 56 gives 8192. Any other code gives 0.
- R4: A write at offset 0xB8 loads one directory entry. Bits 5:0 are the index, bit 8 is present and bits 31:12 are the table page. Bits 11:9 and 7:6 have no effect. A translation that reaches an entry whose present bit is clear faults without a memory read.
- R5: On a miss, mem_rd rises the cycle after the request and stays high, with mem_addr stable, until mem_ack. mem_addr = {table page, address[21:12], 2'b00}.
- R6: If bit 0 of the returned second-level word is clear, the translation faults with paddr=0. Such a result is not cached, so a retry reads memory again.
- R7: A successful translation returns paddr = {entry[31:12], address[11:0]}. Done rises the cycle after the acknowledge.
- R8: A request whose page index is cached completes one cycle after the request, with hit=1 and no memory read.
- R9: Misses refill the four cache slots in round-robin order. After four distinct pages have been loaded into an empty cache, a fifth page evicts the oldest.
- R10: A control write at offset 0xB0 that sets bit 7 while the stored bit 7 is 0 invalidates every cached translation.
- R11: A directory write that arrives while a memory read is outstanding takes effect when that read is acknowledged. An applied directory write invalidates exactly the cached pages under that directory index.
- R12: Control writes that leave bit 7 high, or that clear it, leave cached translations in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| xl_start | input | 1 | Translation request, taken when xl_busy is low |
| xl_addr | input | 32 | Aperture bus address to translate |
| xl_busy | output | 1 | A second-level read is outstanding |
| xl_done | output | 1 | One-cycle completion strobe |
| xl_fault | output | 1 | Completed translation faulted |
| xl_hit | output | 1 | Completed translation came from the cache |
| xl_paddr | output | 32 | Translated physical address, zero on fault |
| mem_rd | output | 1 | Second-level read request |
| mem_addr | output | 32 | Byte address of the second-level entry |
| mem_ack | input | 1 | Read data valid, one cycle |
| mem_rdata | input | 32 | Second-level entry returned by memory |

## Verification
The assertions assume that mem_ack is raised only while mem_rd is high, and for exactly one cycle per request. They also assume that xl_start and xl_addr hold their values for the request cycle only, and that no request is made while xl_busy is high. The bench's memory responder acknowledges a pending read after a programmable delay and then drops the acknowledge. The driver waits for the busy flag to clear before it issues the next request. At most one directory write lands inside any outstanding read, because the deferral register holds a single write.

// File: rtl/gart_pkg.sv
package gart_pkg;
  localparam logic [7:0] REG_BASE = 8'h10;
  localparam logic [7:0] REG_CTRL = 8'hB0;
  localparam logic [7:0] REG_SIZE = 8'hB4;
  localparam logic [7:0] REG_DIR  = 8'hB8;
  localparam int CTRL_FLUSH_BIT = 7;
  localparam int DIR_PRESENT_BIT = 8;

  typedef enum logic {ST_IDLE, ST_WALK} walk_st_t;

  // aperture page count for a size code; unknown codes open no pages
  function automatic logic [16:0] size_to_pages(input logic [7:0] code);
    case (code)
      8'd0:    return 17'd65536;
      8'd32:   return 17'd32768;
      8'd48:   return 17'd16384;
      8'd56:   return 17'd8192;
      default: return 17'd0;
    endcase
  endfunction
endpackage

// File: rtl/gart_dir.sv
module gart_dir
  import gart_pkg::*;
#(
  parameter int DIR_N = 64,
  parameter int PG_W  = 20,
  localparam int IX_W = $clog2(DIR_N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  input  logic            hold,
  input  logic [IX_W-1:0] rd_idx,
  output logic            rd_present,
  output logic [PG_W-1:0] rd_page,
  output logic            inv0_en,
  output logic [IX_W-1:0] inv0_idx,
  output logic            inv1_en,
  output logic [IX_W-1:0] inv1_idx
);
  logic [IX_W-1:0] w_idx;
  logic            w_pr;
  logic [PG_W-1:0] w_pg;
  logic            pend_v_q, pend_v_n;
  logic [IX_W-1:0] pend_idx_q;
  logic            pend_pr_q;
  logic [PG_W-1:0] pend_pg_q;
  logic            pend_load, pend_apply, new_apply;

  logic            pr_q [DIR_N];
  logic [PG_W-1:0] pg_q [DIR_N];

  assign w_idx = wr_data[IX_W-1:0];
  assign w_pr  = wr_data[DIR_PRESENT_BIT];
  assign w_pg  = wr_data[31 -: PG_W];

  assign pend_load  = wr_en && hold;
  assign pend_apply = pend_v_q && !hold;
  assign new_apply  = wr_en && !hold;

  always_comb begin
    pend_v_n = pend_v_q;
    if (pend_load)       pend_v_n = 1'b1;
    else if (pend_apply) pend_v_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q   <= 1'b0;
      pend_idx_q <= '0;
      pend_pr_q  <= 1'b0;
      pend_pg_q  <= '0;
    end else begin
      pend_v_q <= pend_v_n;
      if (pend_load) begin
        pend_idx_q <= w_idx;
        pend_pr_q  <= w_pr;
        pend_pg_q  <= w_pg;
      end
    end
  end

  for (genvar g = 0; g < DIR_N; g++) begin : g_ent
    logic sel_new, sel_pend;
    assign sel_new  = new_apply && (w_idx == IX_W'(g));
    assign sel_pend = pend_apply && (pend_idx_q == IX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pr_q[g] <= 1'b0;
        pg_q[g] <= '0;
      end else if (sel_new) begin
        pr_q[g] <= w_pr;
        pg_q[g] <= w_pg;
      end else if (sel_pend) begin
        pr_q[g] <= pend_pr_q;
        pg_q[g] <= pend_pg_q;
      end
    end
  end

  assign rd_present = pr_q[rd_idx];
  assign rd_page    = pg_q[rd_idx];
  assign inv0_en    = pend_apply;
  assign inv0_idx   = pend_idx_q;
  assign inv1_en    = new_apply;
  assign inv1_idx   = w_idx;
endmodule

// File: rtl/gart_tcache.sv
module gart_tcache #(
  parameter int N     = 4,
  parameter int TAG_W = 20,
  parameter int PG_W  = 20,
  parameter int L2_W  = 10,
  parameter int IX_W  = 6,
  localparam int RR_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [PG_W-1:0]  lk_page,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [PG_W-1:0]  fill_page,
  input  logic             flush,
  input  logic             inv0_en,
  input  logic [IX_W-1:0]  inv0_idx,
  input  logic             inv1_en,
  input  logic [IX_W-1:0]  inv1_idx
);
  logic [RR_W-1:0] rr_q;
  logic [N-1:0]    match;
  logic [PG_W-1:0] pg_sel [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic             v_q, v_n;
    logic [TAG_W-1:0] t_q, t_n;
    logic [PG_W-1:0]  p_q, p_n;
    logic             load;

    assign load = fill_en && (rr_q == RR_W'(g));

    always_comb begin
      v_n = v_q;
      t_n = t_q;
      p_n = p_q;
      if (load) begin
        v_n = 1'b1;
        t_n = fill_tag;
        p_n = fill_page;
      end
      // invalidation is applied after a refill in the same cycle
      if (flush) v_n = 1'b0;
      if (inv0_en && t_n[L2_W +: IX_W] == inv0_idx) v_n = 1'b0;
      if (inv1_en && t_n[L2_W +: IX_W] == inv1_idx) v_n = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
        p_q <= '0;
      end else begin
        v_q <= v_n;
        t_q <= t_n;
        p_q <= p_n;
      end
    end

    assign match[g]  = v_q && (t_q == lk_tag);
    assign pg_sel[g] = match[g] ? p_q : '0;
  end

  always_comb begin
    lk_page = '0;
    for (int i = 0; i < N; i++) lk_page = lk_page | pg_sel[i];
  end
  assign lk_hit = |match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rr_q <= '0;
    else if (fill_en) rr_q <= (rr_q == RR_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/gart_xlate.sv
module gart_xlate
  import gart_pkg::*;
#(
  parameter int DIR_N = 64,
  parameter int L2_W  = 10,
  parameter int TC_N  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        xl_start,
  input  logic [31:0] xl_addr,
  output logic        xl_busy,
  output logic        xl_done,
  output logic        xl_fault,
  output logic        xl_hit,
  output logic [31:0] xl_paddr,
  output logic        mem_rd,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int PG_W   = 20;
  localparam int PIDX_W = PG_W;
  localparam int DX_W   = PIDX_W - L2_W;
  localparam int IX_W   = $clog2(DIR_N);

  logic [DX_W-1:0]   base_q;
  logic [7:0]        size_q;
  logic              ctl7_q;
  logic              base_we, size_we, ctl_we, dir_we, flush;

  walk_st_t          st_q, st_n;
  logic [PIDX_W-1:0] pidx_q, pidx_n;
  logic [11:0]       off_q, off_n;
  logic [31:0]       maddr_q, maddr_n;
  logic              done_q, done_n, fault_q, fault_n, hit_q, hit_n;
  logic [31:0]       pa_q, pa_n;

  logic [DX_W-1:0]   dix;
  logic [PIDX_W-1:0] pidx;
  logic              in_rng, accept, hold, walk_end, fill_en;
  logic              dir_pr, tc_hit;
  logic [PG_W-1:0]   dir_pg, tc_pg;
  logic              inv0_en, inv1_en;
  logic [IX_W-1:0]   inv0_idx, inv1_idx;

  assign base_we = cfg_we && (cfg_addr == REG_BASE);
  assign size_we = cfg_we && (cfg_addr == REG_SIZE);
  assign ctl_we  = cfg_we && (cfg_addr == REG_CTRL);
  assign dir_we  = cfg_we && (cfg_addr == REG_DIR);
  assign flush   = ctl_we && cfg_wdata[CTRL_FLUSH_BIT] && !ctl7_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      ctl7_q <= 1'b1;
    end else begin
      if (base_we) base_q <= cfg_wdata[31 -: DX_W];
      if (size_we) size_q <= cfg_wdata[7:0];
      if (ctl_we)  ctl7_q <= cfg_wdata[CTRL_FLUSH_BIT];
    end
  end

  assign dix      = xl_addr[31 -: DX_W] - base_q;
  assign pidx     = {dix, xl_addr[12 +: L2_W]};
  assign in_rng   = pidx < PIDX_W'(size_to_pages(size_q));
  assign accept   = xl_start && (st_q == ST_IDLE);
  assign hold     = (st_q == ST_WALK) && !mem_ack;
  assign walk_end = (st_q == ST_WALK) && mem_ack;
  assign fill_en  = walk_end && mem_rdata[0];

  gart_dir #(.DIR_N(DIR_N), .PG_W(PG_W)) u_dir (
    .clk(clk), .rst_n(rst_n), .wr_en(dir_we), .wr_data(cfg_wdata), .hold(hold),
    .rd_idx(dix[IX_W-1:0]), .rd_present(dir_pr), .rd_page(dir_pg),
    .inv0_en(inv0_en), .inv0_idx(inv0_idx), .inv1_en(inv1_en), .inv1_idx(inv1_idx)
  );

  gart_tcache #(.N(TC_N), .TAG_W(PIDX_W), .PG_W(PG_W), .L2_W(L2_W), .IX_W(IX_W)) u_tc (
    .clk(clk), .rst_n(rst_n), .lk_tag(pidx), .lk_hit(tc_hit), .lk_page(tc_pg),
    .fill_en(fill_en), .fill_tag(pidx_q), .fill_page(mem_rdata[31 -: PG_W]),
    .flush(flush), .inv0_en(inv0_en), .inv0_idx(inv0_idx),
    .inv1_en(inv1_en), .inv1_idx(inv1_idx)
  );

  always_comb begin
    st_n    = st_q;
    pidx_n  = pidx_q;
    off_n   = off_q;
    maddr_n = maddr_q;
    done_n  = 1'b0;
    fault_n = fault_q;
    hit_n   = hit_q;
    pa_n    = pa_q;
    if (accept) begin
      if (!in_rng) begin
        done_n = 1'b1; fault_n = 1'b1; hit_n = 1'b0; pa_n = '0;
      end else if (tc_hit) begin
        done_n = 1'b1; fault_n = 1'b0; hit_n = 1'b1; pa_n = {tc_pg, xl_addr[11:0]};
      end else if (!dir_pr) begin
        done_n = 1'b1; fault_n = 1'b1; hit_n = 1'b0; pa_n = '0;
      end else begin
        st_n    = ST_WALK;
        pidx_n  = pidx;
        off_n   = xl_addr[11:0];
        maddr_n = {dir_pg, pidx[L2_W-1:0], 2'b00};
      end
    end else if (walk_end) begin
      st_n   = ST_IDLE;
      done_n = 1'b1;
      hit_n  = 1'b0;
      if (mem_rdata[0]) begin
        fault_n = 1'b0; pa_n = {mem_rdata[31 -: PG_W], off_q};
      end else begin
        fault_n = 1'b1; pa_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pidx_q  <= '0;
      off_q   <= '0;
      maddr_q <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      hit_q   <= 1'b0;
      pa_q    <= '0;
    end else begin
      st_q    <= st_n;
      pidx_q  <= pidx_n;
      off_q   <= off_n;
      maddr_q <= maddr_n;
      done_q  <= done_n;
      fault_q <= fault_n;
      hit_q   <= hit_n;
      pa_q    <= pa_n;
    end
  end

  assign xl_busy  = (st_q == ST_WALK);
  assign xl_done  = done_q;
  assign xl_fault = fault_q;
  assign xl_hit   = hit_q;
  assign xl_paddr = pa_q;
  assign mem_rd   = (st_q == ST_WALK);
  assign mem_addr = maddr_q;
endmodule

// File: rtl/gart_xlate_chk.sv
module gart_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        xl_start,
  input logic [31:0] xl_addr,
  input logic        xl_busy,
  input logic        xl_done,
  input logic        xl_fault,
  input logic        xl_hit,
  input logic [31:0] xl_paddr,
  input logic        mem_rd,
  input logic [31:0] mem_addr,
  input logic        mem_ack,
  input logic [31:0] mem_rdata
);
  p_fault_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xl_done && xl_fault |-> xl_paddr == 32'h0);

  p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && !mem_ack |=> mem_rd && $stable(mem_addr));

  p_busy_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xl_busy |-> !xl_done);

  p_ack_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && mem_ack |=> xl_done && !xl_hit);

  p_bad_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && mem_ack && !mem_rdata[0] |=> xl_fault);

  p_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && mem_ack && mem_rdata[0] |=> !xl_fault && xl_paddr[31:12] == $past(mem_rdata[31:12]));

  p_hit_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xl_done && xl_hit |-> !xl_fault && $past(xl_start) && !$past(xl_busy)
      && xl_paddr[11:0] == $past(xl_addr[11:0]));
endmodule

bind gart_xlate gart_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xl_start(xl_start), .xl_addr(xl_addr),
  .xl_busy(xl_busy), .xl_done(xl_done), .xl_fault(xl_fault), .xl_hit(xl_hit),
  .xl_paddr(xl_paddr), .mem_rd(mem_rd), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .mem_rdata(mem_rdata)
);

// File: tb/sim_gart_xlate.sv
`timescale 1ns/1ps
module sim_gart_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        xl_start;
  logic [31:0] xl_addr;
  logic        xl_busy, xl_done, xl_fault, xl_hit;
  logic [31:0] xl_paddr;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  int checks = 0;
  int errors = 0;
  int nreads = 0;
  int lat = 2;
  int lat_cnt = 0;
  logic [31:0] last_maddr = '0;
  logic [32:0] q_exp [$];
  string       q_req [$];
  bit          finished = 0;

  always #4 clk = ~clk;

  gart_xlate u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .xl_start(xl_start), .xl_addr(xl_addr), .xl_busy(xl_busy), .xl_done(xl_done),
    .xl_fault(xl_fault), .xl_hit(xl_hit), .xl_paddr(xl_paddr),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // second-level table contents: index 0x3FF is unmapped, others map
  function automatic logic [31:0] mdl(input logic [31:0] ma);
    if (ma[11:2] == 10'h3FF) return 32'h0;
    return {ma[31:12] ^ {10'h0, ma[11:2]}, 11'h0, 1'b1};
  endfunction

  function automatic logic [31:0] maof(input logic [19:0] tpage, input logic [31:0] a);
    return {tpage, a[21:12], 2'b00};
  endfunction

  function automatic logic [31:0] paof(input logic [31:0] a, input logic [31:0] ma);
    logic [31:0] e;
    e = mdl(ma);
    return {e[31:12], a[11:0]};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // memory responder
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_rd && !mem_ack) begin
        if (lat_cnt >= lat) begin
          mem_ack = 1'b1;
          mem_rdata = mdl(mem_addr);
          last_maddr = mem_addr;
          nreads++;
          lat_cnt = 0;
        end else lat_cnt++;
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && xl_done) begin
        if (q_exp.size() == 0) begin
          chk(1'b0, "R8", "unexpected done", {31'h0, xl_done}, 32'h0);
        end else begin
          logic [32:0] e;
          string r;
          e = q_exp.pop_front();
          r = q_req.pop_front();
          chk(xl_fault == e[32], r, "fault", {31'h0, xl_fault}, {31'h0, e[32]});
          chk(xl_paddr == e[31:0], r, "paddr", xl_paddr, e[31:0]);
        end
      end
    end
  end

  task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] dirw(input int idx, input logic [19:0] pg, input bit pr);
    return {pg, 3'b101, pr, 2'b11, 6'(idx)};
  endfunction

  task automatic tx(input logic [31:0] a, input bit ehit, input bit efault, input bit emrd,
                    input logic [31:0] emaddr, input logic [31:0] epa, input string rq);
    int r0;
    bit hit_seen;
    r0 = nreads;
    @(negedge clk);
    xl_start = 1'b1; xl_addr = a;
    q_exp.push_back({efault, epa});
    q_req.push_back(rq);
    @(negedge clk);
    xl_start = 1'b0;
    xl_addr = 32'hDEAD_BEEF;
    while (xl_busy) @(negedge clk);
    hit_seen = xl_hit;
    chk(hit_seen == ehit, rq, "hit flag", {31'h0, hit_seen}, {31'h0, ehit});
    chk((nreads - r0) == int'(emrd), rq, "memory reads", 32'(nreads - r0), {31'h0, emrd});
    if (emrd) chk(last_maddr == emaddr, rq, "mem_addr", last_maddr, emaddr);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, ma;
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    xl_start = 1'b0; xl_addr = '0;
    repeat (3) @(negedge clk);
    chk(!xl_done && !mem_rd && !xl_busy, "R1", "reset outputs",
        {29'h0, xl_done, mem_rd, xl_busy}, 32'h0);
    rst_n = 1'b1;

    cfg_wr(8'h10, 32'h8000_0000);
    cfg_wr(8'hB4, 32'd56);
    for (int i = 0; i <= 16; i++) cfg_wr(8'hB8, dirw(i, 20'h00100 + 20'(i), 1'b1));
    cfg_wr(8'hB8, 32'h0000_0003); // R4: index only, present clear

    // R1/R5/R7 first translation misses
    a = 32'h8000_1234; ma = maof(20'h00100, a);
    tx(a, 0, 0, 1, ma, paof(a, ma), "R1 R5 R7 first miss");
    // R8 hit
    tx(32'h8000_1ABC, 1, 0, 0, 0, paof(32'h8000_1ABC, ma), "R8 hit");
    // R2 below base, above limit
    tx(32'h7FFF_F000, 0, 1, 0, 0, 0, "R2 below base");
    tx(32'h8200_0000, 0, 1, 0, 0, 0, "R2 above 32MB");
    // R3 size codes
    cfg_wr(8'hB4, 32'd48);
    a = 32'h8200_0ABC; ma = maof(20'h00108, a);
    tx(a, 0, 0, 1, ma, paof(a, ma), "R3 code48");
    tx(32'h8400_0010, 0, 1, 0, 0, 0, "R3 code48 limit");
    cfg_wr(8'hB4, 32'd32);
    a = 32'h8400_0010; ma = maof(20'h00110, a);
    tx(a, 0, 0, 1, ma, paof(a, ma), "R3 code32");
    cfg_wr(8'hB4, 32'd5);
    tx(32'h8000_1000, 0, 1, 0, 0, 0, "R3 unknown code");
    cfg_wr(8'hB4, 32'd0);
    tx(32'h8000_1000, 1, 0, 0, 0, 32'h0010_1000, "R3 code0");
    // R4 not present
    tx(32'h80C0_0000, 0, 1, 0, 0, 0, "R4 absent entry");
    // R6 invalid second-level entry, not cached
    a = 32'h803F_F000; ma = maof(20'h00100, a);
    tx(a, 0, 1, 1, ma, 0, "R6 invalid entry");
    tx(a, 0, 1, 1, ma, 0, "R6 retry reads again");
    // R12 writes that do not flush
    cfg_wr(8'hB0, 32'h0000_2280);
    tx(32'h8000_1000, 1, 0, 0, 0, 32'h0010_1000, "R12 bit7 kept high");
    cfg_wr(8'hB0, 32'h0000_2200);
    tx(32'h8000_1000, 1, 0, 0, 0, 32'h0010_1000, "R12 bit7 cleared");
    // R10 rise flushes
    cfg_wr(8'hB0, 32'h0000_2280);
    a = 32'h8000_1000; ma = maof(20'h00100, a);
    tx(a, 0, 0, 1, ma, paof(a, ma), "R10 flush");
    // R9 round robin
    cfg_wr(8'hB0, 32'h0000_2200);
    cfg_wr(8'hB0, 32'h0000_2280);
    for (int k = 2; k <= 5; k++) begin
      a = 32'h8000_0000 + 32'(k) * 32'h1000; ma = maof(20'h00100, a);
      tx(a, 0, 0, 1, ma, paof(a, ma), "R9 fill");
    end
    for (int k = 2; k <= 5; k++) begin
      a = 32'h8000_0000 + 32'(k) * 32'h1000; ma = maof(20'h00100, a);
      tx(a, 1, 0, 0, 0, paof(a, ma), "R9 all four held");
    end
    a = 32'h8000_6000; ma = maof(20'h00100, a);
    tx(a, 0, 0, 1, ma, paof(a, ma), "R9 fifth page");
    a = 32'h8000_2000; ma = maof(20'h00100, a);
    tx(a, 0, 0, 1, ma, paof(a, ma), "R9 oldest evicted");
    a = 32'h8000_4000; ma = maof(20'h00100, a);
    tx(a, 1, 0, 0, 0, paof(a, ma), "R9 third kept");
    a = 32'h8000_3000; ma = maof(20'h00100, a);
    tx(a, 0, 0, 1, ma, paof(a, ma), "R9 second evicted");
    // R11 deferred directory write
    a = 32'h8040_5000; ma = maof(20'h00101, a);
    tx(a, 0, 0, 1, ma, paof(a, ma), "R11 prime");
    tx(a, 1, 0, 0, 0, paof(a, ma), "R11 prime hit");
    lat = 6;
    a = 32'h8040_6000; ma = maof(20'h00101, a);
    fork
      tx(a, 0, 0, 1, ma, paof(a, ma), "R11 in-flight uses old table");
      begin
        repeat (3) @(negedge clk);
        cfg_wr(8'hB8, dirw(1, 20'h00200, 1'b1));
      end
    join
    lat = 2;
    a = 32'h8000_2000; ma = maof(20'h00100, a);
    tx(a, 1, 0, 0, 0, paof(a, ma), "R11 other index kept");
    a = 32'h8040_5000; ma = maof(20'h00200, a);
    tx(a, 0, 0, 1, ma, paof(a, ma), "R11 stale page dropped");
    a = 32'h8040_6000; ma = maof(20'h00200, a);
    tx(a, 0, 0, 1, ma, paof(a, ma), "R11 refill during write dropped");

    repeat (4) @(negedge clk);
    chk(q_exp.size() == 0, "R7", "pending results", 32'(q_exp.size()), 32'h0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule